// File: doc/BRIEF.md
# Rate-1/4 Serial Concatenated Encoder with Field-Tagged Output

This block encodes frames of N information bits with two identical recursive systematic convolutional encoders in series. The outer encoder runs over the N input bits and yields a systematic stream and a parity stream. Both streams go into a frame buffer. A structured interleaver reads that buffer back as a 2N-bit frame. The first N positions of that frame are the outer systematic bits, shuffled among themselves. The last N positions are the outer parity bits, shuffled among themselves. The inner encoder consumes this 2N-bit frame, so it makes two steps for every outer step. Each output beat carries one inner systematic bit and one inner parity bit. The overall rate is therefore 1/4.

Each output bit belongs to one of four codeword fields. The field depends on two things: whether the bit is an inner systematic or an inner parity bit, and whether it comes from the first or the second half of the interleaved frame. Each beat carries a field code for both of its bits. A downstream puncturing stage can use these codes to pick which fields to keep. Both sub-interleavers are affine permutations, pos(j) = (MUL·j + OFS) mod N, and they stand in for a randomised mapping. The block takes no new frame until the current frame has fully drained. Both encoders start every frame from the all-zero state.

Top module: `sccc_hybrid_enc`

## Requirements
- R1: After a synchronous active-low reset, in_ready is 1 and out_valid is 0.
- R2: The block is always in exactly one of two phases, accepting input or emitting output. It accepts exactly N input bits per frame. While a frame drains, in_ready stays 0 and input activity has no effect on the output.
- R3: Each frame gives exactly 2N output handshakes. out_last is 1 only on beat 2N-1. On the cycle after that beat, in_ready is 1 and out_valid is 0.
- R4: The field code is 2 bits: 00 for systematic-of-systematic, 01 for outer-parity-through-inner-systematic, 10 for inner-only parity, 11 for double parity. On beats 0..N-1, out_sys_field is 00 and out_par_field is 10. On beats N..2N-1, out_sys_field is 01 and out_par_field is 11.
- R5: On beat j < N, out_sys equals the input bit u[(SYS_MUL·j + SYS_OFS) mod N]. Input bits are indexed in order of acceptance, starting at 0.
- R6: On beat N+j, out_sys equals the outer parity bit p[(PAR_MUL·j + PAR_OFS) mod N]. Each constituent encoder has states s1..s4, all zero at frame start. For each input bit d, the feedback bit is w = d ^ s1 ^ s4 (feedback polynomial 23 octal, 1+D+D^4). The parity bit is w ^ s2 ^ s3 ^ s4 (feedforward polynomial 35 octal, 1+D^2+D^3+D^4). The state then shifts, with s1 taking w.
- R7: out_par is the parity of that same encoder run over the 2N-bit interleaved sequence in beat order. The encoder starts from zero for each frame.
- R8: While out_valid is 1 and out_ready is 0, every output holds its value on the next cycle.
- R9: An input cycle with in_valid at 0 is ignored, whatever the value on in_bit.
- R10: Frames do not affect one another. A frame repeated after other frames gives the same output as it would after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input bit is valid |
| in_ready | output | 1 | Block accepts an input bit |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_sys | output | 1 | Inner systematic bit |
| out_par | output | 1 | Inner parity bit |
| out_sys_field | output | 2 | Field code of out_sys |
| out_par_field | output | 2 | Field code of out_par |
| out_last | output | 1 | Final beat of the frame |

## Verification
The hardest case is backpressure at the two internal turning points. The first is the beat where the read side switches from the systematic half to the parity half. There, the interleaver address, the data source and the field codes all change together while the inner encoder state must carry over. The second is the final beat, where the outer encoder must clear. The stimulus uses periodic stall patterns whose period does not divide N, so stalls fall on these beats in some frames. Input gaps carry inverted data bits. During drains, the stimulus drives in_valid high with toggling bits. A frame is also repeated after different frames to show that no state leaks from one frame to the next.

// File: rtl/sccc_pkg.sv
// Shared constants and types for the serial concatenated encoder.
// Polynomial bit k is the coefficient of D^k.
package sccc_pkg;
    localparam int unsigned MEM_K = 4;
    localparam logic [MEM_K:0] FB_POLY = 5'o23;
    localparam logic [MEM_K:0] FF_POLY = 5'o35;

    typedef enum logic [1:0] {
        FLD_SYS_SYS = 2'b00,
        FLD_PAR_SYS = 2'b01,
        FLD_SYS_PAR = 2'b10,
        FLD_PAR_PAR = 2'b11
    } field_e;

    typedef enum logic {
        PH_LOAD  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;
endpackage

// File: rtl/sccc_rsc_enc.sv
// Recursive systematic convolutional encoder with one bit per step.
// par_o is combinational from the current state and din. The state
// advances on step. clear returns the state to zero and wins over step.
// Assumes FB[0] is 1; that bit is implied and not used.
module sccc_rsc_enc
    import sccc_pkg::*;
#(
    parameter int unsigned K = MEM_K,
    parameter logic [K:0]  FB = FB_POLY,
    parameter logic [K:0]  FF = FF_POLY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic din,
    output logic par_o
);
    logic [K:1] st_q;
    logic       w;

    // Feedback bit and parity from the state taps.
    always_comb begin
        w     = din ^ (^(st_q & FB[K:1]));
        par_o = (FF[0] & w) ^ (^(st_q & FF[K:1]));
    end

    // Shift register: s1 takes w, sk takes s(k-1).
    always_ff @(posedge clk) begin
        if (!rst_n || clear) st_q <= '0;
        else if (step)       st_q <= {st_q[K-1:1], w};
    end
endmodule

// File: rtl/sccc_perm_addr.sv
// Address walker for the affine permutation (MUL*j + OFS) mod N.
// It adds MUL mod N on each advance, so it needs no multiplier.
// restart sets the address back to OFS mod N.
// Assumes N >= 2 and MUL coprime to N.
module sccc_perm_addr #(
    parameter int unsigned N   = 16,
    parameter int unsigned MUL = 5,
    parameter int unsigned OFS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 advance,
    output logic [$clog2(N)-1:0] addr_o
);
    localparam int unsigned AW = $clog2(N);
    localparam logic [AW:0] N_W   = (AW+1)'(N);
    localparam logic [AW:0] MUL_W = (AW+1)'(MUL % N);
    localparam logic [AW:0] OFS_W = (AW+1)'(OFS % N);

    logic [AW-1:0] addr_q;
    logic [AW:0]   sum, nxt;

    // Modular add with a single conditional subtraction.
    always_comb begin
        sum = {1'b0, addr_q} + MUL_W;
        nxt = (sum >= N_W) ? sum - N_W : sum;
    end

    // Address register.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) addr_q <= OFS_W[AW-1:0];
        else if (advance)      addr_q <= nxt[AW-1:0];
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/sccc_frame_buf.sv
// Two N-entry bit memories: one for the outer systematic bits and one for
// the outer parity bits. Both share one write port. Each has its own
// asynchronous read port. No reset, because every entry is written
// before it is read.
module sccc_frame_buf #(
    parameter int unsigned N = 16
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic                 wsys,
    input  logic                 wpar,
    input  logic [$clog2(N)-1:0] raddr_sys,
    input  logic [$clog2(N)-1:0] raddr_par,
    output logic                 rsys,
    output logic                 rpar
);
    logic [N-1:0] sys_mem;
    logic [N-1:0] par_mem;

    // Write the outer encoder outputs at the input index.
    always_ff @(posedge clk) begin
        if (we) begin
            sys_mem[waddr] <= wsys;
            par_mem[waddr] <= wpar;
        end
    end

    assign rsys = sys_mem[raddr_sys];
    assign rpar = par_mem[raddr_par];
endmodule

// File: rtl/sccc_hybrid_enc.sv
// Frame-based rate-1/4 serial concatenated encoder.
// LOAD phase: accepts N bits, runs the outer encoder and buffers its
// systematic and parity outputs.
// DRAIN phase: emits 2N beats. The systematic half is read through one
// affine permutation, then the parity half through another. Each bit
// feeds the inner encoder, and each beat is tagged with its field codes.
// Outputs are combinational from registered state, so a stalled beat
// holds by itself.
module sccc_hybrid_enc
    import sccc_pkg::*;
#(
    parameter int unsigned N       = 16,
    parameter int unsigned SYS_MUL = 5,
    parameter int unsigned SYS_OFS = 3,
    parameter int unsigned PAR_MUL = 7,
    parameter int unsigned PAR_OFS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_bit,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_sys,
    output logic       out_par,
    output logic [1:0] out_sys_field,
    output logic [1:0] out_par_field,
    output logic       out_last
);
    localparam int unsigned AW = $clog2(N);
    localparam logic [AW-1:0] WR_LAST = AW'(N - 1);
    localparam logic [AW:0]   RD_HALF = (AW+1)'(N);
    localparam logic [AW:0]   RD_LAST = (AW+1)'(2*N - 1);

    phase_e        phase_q;
    logic [AW-1:0] wr_idx_q;
    logic [AW:0]   rd_idx_q;
    logic          in_fire, out_fire, load_done, drain_done, second_half;
    logic          outer_par, inner_din;
    logic [AW-1:0] sys_addr, par_addr;
    logic          rd_sys, rd_par;

    // Handshake and phase-boundary decode.
    always_comb begin
        in_ready    = (phase_q == PH_LOAD);
        out_valid   = (phase_q == PH_DRAIN);
        in_fire     = in_valid && in_ready;
        out_fire    = out_valid && out_ready;
        load_done   = in_fire && (wr_idx_q == WR_LAST);
        drain_done  = out_fire && (rd_idx_q == RD_LAST);
        second_half = (rd_idx_q >= RD_HALF);
    end

    // Phase register: LOAD -> DRAIN after N inputs, back after 2N outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase_q <= PH_LOAD;
        else if (load_done)  phase_q <= PH_DRAIN;
        else if (drain_done) phase_q <= PH_LOAD;
    end

    // Write index over the input frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_idx_q <= '0;
        else if (in_fire) wr_idx_q <= load_done ? '0 : wr_idx_q + 1'b1;
    end

    // Read index over the 2N-beat output frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_idx_q <= '0;
        else if (out_fire) rd_idx_q <= drain_done ? '0 : rd_idx_q + 1'b1;
    end

    sccc_rsc_enc u_outer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (drain_done),
        .step  (in_fire),
        .din   (in_bit),
        .par_o (outer_par)
    );

    sccc_frame_buf #(.N(N)) u_buf (
        .clk       (clk),
        .we        (in_fire),
        .waddr     (wr_idx_q),
        .wsys      (in_bit),
        .wpar      (outer_par),
        .raddr_sys (sys_addr),
        .raddr_par (par_addr),
        .rsys      (rd_sys),
        .rpar      (rd_par)
    );

    sccc_perm_addr #(.N(N), .MUL(SYS_MUL), .OFS(SYS_OFS)) u_perm_sys (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_done),
        .advance (out_fire && !second_half),
        .addr_o  (sys_addr)
    );

    sccc_perm_addr #(.N(N), .MUL(PAR_MUL), .OFS(PAR_OFS)) u_perm_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_done),
        .advance (out_fire && second_half),
        .addr_o  (par_addr)
    );

    assign inner_din = second_half ? rd_par : rd_sys;

    sccc_rsc_enc u_inner (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load_done),
        .step  (out_fire),
        .din   (inner_din),
        .par_o (out_par)
    );

    // Output bit and field codes for the current beat.
    always_comb begin
        out_sys       = inner_din;
        out_sys_field = second_half ? FLD_PAR_SYS : FLD_SYS_SYS;
        out_par_field = second_half ? FLD_PAR_PAR : FLD_SYS_PAR;
        out_last      = (rd_idx_q == RD_LAST);
    end
endmodule

// File: rtl/sccc_hybrid_enc_sva.sv
// Port-level checker for sccc_hybrid_enc. It keeps its own input and
// output beat counters per frame, then checks the phases, the frame
// length, the field codes and the hold behaviour under stall.
module sccc_hybrid_enc_sva #(
    parameter int unsigned N = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_sys,
    input logic       out_par,
    input logic [1:0] out_sys_field,
    input logic [1:0] out_par_field,
    input logic       out_last
);
    localparam int unsigned CW = $clog2(2*N) + 1;
    localparam logic [CW-1:0] IN_MAX  = CW'(N);
    localparam logic [CW-1:0] OUT_END = CW'(2*N - 1);

    logic [CW-1:0] in_cnt, out_cnt;

    // Count accepted inputs and outputs in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cnt  <= '0;
            out_cnt <= '0;
        end else if (out_valid && out_ready && out_last) begin
            in_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            if (in_valid && in_ready)   in_cnt  <= in_cnt + 1'b1;
            if (out_valid && out_ready) out_cnt <= out_cnt + 1'b1;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (in_ready && !out_valid));

    a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready != out_valid);

    a_r2_input_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (in_cnt < IN_MAX));

    a_r3_last_position: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (out_cnt == OUT_END)));

    a_r3_back_to_load: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

    a_r4_field_pair: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_sys_field == 2'b00 && out_par_field == 2'b10) ||
                       (out_sys_field == 2'b01 && out_par_field == 2'b11)));

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sys) &&
            $stable(out_par) && $stable(out_sys_field) &&
            $stable(out_par_field) && $stable(out_last)));
endmodule

bind sccc_hybrid_enc sccc_hybrid_enc_sva #(.N(N)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_sys       (out_sys),
    .out_par       (out_par),
    .out_sys_field (out_sys_field),
    .out_par_field (out_par_field),
    .out_last      (out_last)
);

// File: tb/sccc_hybrid_enc_tb.sv
`timescale 1ns/1ps
// Directed bench. A behavioural reference encoder gives the expected
// value of every beat. Inputs are driven and outputs sampled on the
// falling edge.
module sccc_hybrid_enc_tb_top;
    localparam int N = 16;
    localparam int SM = 5, SO = 3, PM = 7, PO = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid, out_sys, out_par, out_last;
    logic [1:0] out_sys_field, out_par_field;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sccc_hybrid_enc #(.N(N), .SYS_MUL(SM), .SYS_OFS(SO), .PAR_MUL(PM), .PAR_OFS(PO)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
        .out_sys(out_sys), .out_par(out_par), .out_sys_field(out_sys_field),
        .out_par_field(out_par_field), .out_last(out_last)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One reference step: taps 1+D+D^4 for feedback and 1+D^2+D^3+D^4
    // for feedforward. st[0] is s1.
    function automatic logic rsc_step(input logic d, inout logic [3:0] st);
        logic w, p;
        w  = d ^ st[0] ^ st[3];
        p  = w ^ st[1] ^ st[2] ^ st[3];
        st = {st[2:0], w};
        return p;
    endfunction

    // Reference: outer encoding, affine interleaving, inner encoding.
    task automatic ref_encode(input logic [N-1:0] u, output logic [2*N-1:0] vs, output logic [2*N-1:0] vp);
        logic [N-1:0] op;
        logic [3:0] st;
        st = '0;
        for (int i = 0; i < N; i++) op[i] = rsc_step(u[i], st);
        for (int j = 0; j < N; j++) begin
            vs[j]     = u[(SM*j + SO) % N];
            vs[N + j] = op[(PM*j + PO) % N];
        end
        st = '0;
        for (int j = 0; j < 2*N; j++) vp[j] = rsc_step(vs[j], st);
    endtask

    // Loads one frame, drains it and checks every beat.
    task automatic run_frame(input logic [N-1:0] u, input int gap, input int stall, input bit poke, input string xt);
        logic [2*N-1:0] vs, vp;
        int idx, beat, cyc;
        logic ps, pp, pl;
        logic [1:0] psf, ppf;
        bit was_stall;
        ref_encode(u, vs, vp);
        idx = 0; cyc = 0;
        while (idx < N) begin
            @(negedge clk);
            cyc++;
            chk({"R2 ", xt}, "in_ready during load", in_ready, 1);
            chk({"R2 ", xt}, "out_valid during load", out_valid, 0);
            if (gap != 0 && cyc % gap == 0) begin
                in_valid = 1'b0; in_bit = ~u[idx];   // R9: ignored bit
            end else begin
                in_valid = 1'b1; in_bit = u[idx];
            end
            if (in_valid && in_ready) idx++;
        end
        beat = 0; cyc = 0; was_stall = 1'b0;
        ps = 1'b0; pp = 1'b0; pl = 1'b0; psf = '0; ppf = '0;
        while (beat < 2*N && cyc < 10*N) begin
            @(negedge clk);
            cyc++;
            in_valid  = poke;
            in_bit    = cyc[0];
            out_ready = !(stall != 0 && cyc % stall == 0);
            chk({"R2 ", xt}, "in_ready during drain", in_ready, 0);
            chk({"R3 ", xt}, "out_valid during drain", out_valid, 1);
            if (was_stall) begin
                chk({"R8 ", xt}, "held sys", out_sys, ps);
                chk({"R8 ", xt}, "held par", out_par, pp);
                chk({"R8 ", xt}, "held fields", {out_sys_field, out_par_field}, {psf, ppf});
                chk({"R8 ", xt}, "held last", out_last, pl);
            end
            if (beat < N) begin
                chk({"R5 R9 ", xt}, $sformatf("sys beat %0d", beat), out_sys, vs[beat]);
                chk({"R4 ", xt}, "first-half fields", {out_sys_field, out_par_field}, 4'b0010);
            end else begin
                chk({"R6 ", xt}, $sformatf("sys beat %0d", beat), out_sys, vs[beat]);
                chk({"R4 ", xt}, "second-half fields", {out_sys_field, out_par_field}, 4'b0111);
            end
            chk({"R7 ", xt}, $sformatf("par beat %0d", beat), out_par, vp[beat]);
            chk({"R3 ", xt}, $sformatf("last beat %0d", beat), out_last, (beat == 2*N-1));
            ps = out_sys; pp = out_par; pl = out_last; psf = out_sys_field; ppf = out_par_field;
            was_stall = out_valid && !out_ready;
            if (out_valid && out_ready) beat++;
        end
        chk({"R3 ", xt}, "beat count", beat, 2*N);
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        chk({"R3 ", xt}, "in_ready after last", in_ready, 1);
        chk({"R3 ", xt}, "out_valid after last", out_valid, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "in_ready after reset", in_ready, 1);
        chk("R1", "out_valid after reset", out_valid, 0);
    endtask

    task automatic t_zeros;    run_frame('0, 0, 0, 1'b0, "zeros");             endtask
    task automatic t_impulse;  run_frame(16'h0001, 0, 0, 1'b0, "impulse");     endtask
    task automatic t_gaps;     run_frame(16'hB4E1, 3, 3, 1'b0, "gaps");        endtask
    task automatic t_poke;     run_frame(16'h5A3C, 2, 5, 1'b1, "R2 poke");     endtask
    task automatic t_dense;    run_frame(16'hFFFF, 0, 7, 1'b1, "ones");        endtask
    task automatic t_repeat;   run_frame(16'hB4E1, 0, 0, 1'b0, "R10 repeat");  endtask

    initial begin
        t_reset();
        t_zeros();
        t_impulse();
        t_gaps();
        t_poke();
        t_dense();
        t_repeat();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule